// File: doc/BRIEF.md
# Three-Wire Serial Divider Loader

This block takes a three-wire serial programming stream (data, shift clock, load enable) and turns it into two sets of parallel divider settings for a frequency synthesizer. One set is the reference word: a 14-bit reference count and a one-bit prescaler select. The other set is the programmable word: a 7-bit swallow count and an 11-bit main count. Both words travel on the same wires. The last bit of each word is a control bit, and that bit decides which of the two holding latches takes the word.

All three serial pins are asynchronous to the system clock `clk_i`. Each pin passes through its own synchronizer. Rising edges of the shift clock and of the load enable are found in the system clock domain. A word is sent least significant bit first, so its control bit ends up in the newest position of a 19-bit shift register. A rising edge on load enable copies the shift register into the latch that the control bit selects. While load enable is high, shift clock edges are ignored. The load enable pin rests high when it is not driven.

Top module: `sdl_loader`

## Requirements
- R1: While reset is asserted, the outputs take their default values (reference count 100, select 0, swallow count 5, main count 200) and the shift register is cleared. A load enable rising edge that follows with no shifted bits therefore loads swallow count 0 and main count 0.
- R2: On each rising edge of the shift clock seen while load enable is low, the synchronized data pin is shifted in. Bits are sent least significant bit first, and the newest bit sits at the control position.
- R3: A load enable rising edge with control bit 1 loads the reference latch: the reference count is taken from word bits 0..13 and the prescaler select from word bit 14. The programmable latch keeps its value.
- R4: A load enable rising edge with control bit 0 loads the programmable latch: the swallow count is taken from word bits 0..6 and the main count from word bits 7..17. The reference latch keeps its value.
- R5: A 16-bit reference word decodes correctly after any bits shifted in earlier. Only the last 16 shifted bits are used.
- R6: Shift clock edges while load enable is high leave the shift register unchanged.
- R7: A transfer happens only on a rising edge of load enable. Holding load enable high does not repeat the transfer. A shift clock edge that is synchronized in the same cycle as a load enable rise is dropped.
- R8: The outputs change only in the cycle after a transfer. Shifting alone never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous, sampled on its rising edge |
| ser_le_i | input | 1 | Load enable, asynchronous, transfer on its rising edge |
| r_cnt_o | output | 14 | Latched reference count |
| sw_o | output | 1 | Latched prescaler select |
| a_cnt_o | output | 7 | Latched swallow count |
| n_cnt_o | output | 11 | Latched main count |

## Verification
A shift clock rise and a load enable rise can reach the synchronized domain in the same cycle. The bench provokes this by raising both pins at the same system clock edge, right after a complete programmable word whose extra bit would otherwise make the control bit 1. Dropping that shift gives the expected result: the programmable latch takes the intended word and the reference latch keeps its value. A behavioural model that tracks pin history in queues is compared with the outputs on every clock, so it also catches a shift that is taken at the wrong moment.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int unsigned REF_CNT_W = 14;
  localparam int unsigned SWAL_W    = 7;
  localparam int unsigned MAIN_W    = 11;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= RST_VAL;
      else if (i == 0) q[i] <= async_i;
      else q[i] <= q[(i == 0) ? 0 : i-1];
    end
  end

  assign level_o = q[STAGES-1];
endmodule

// File: rtl/sdl_edge.sv
module sdl_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

  // one transfer per pin rise
  p_single_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sdl_shift.sv
module sdl_shift #(
  parameter int unsigned LEN = 19
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_en_i,
  input  logic           bit_i,
  output logic [LEN-1:0] sr_o
);
  // newest bit enters at the top, so LSB-first words end right-aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= '0;
    else if (shift_en_i) sr_o <= {bit_i, sr_o[LEN-1:1]};
  end
endmodule

// File: rtl/sdl_latch.sv
module sdl_latch #(
  parameter int unsigned   W   = 8,
  parameter logic [W-1:0]  DEF = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= DEF;
    else if (load_i) q_o <= d_i;
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/sdl_loader.sv
module sdl_loader
  import sdl_pkg::*;
#(
  parameter int unsigned      R_W         = REF_CNT_W,
  parameter int unsigned      A_W         = SWAL_W,
  parameter int unsigned      N_W         = MAIN_W,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [R_W-1:0]   DEF_R       = 100,
  parameter logic             DEF_SW      = 1'b0,
  parameter logic [A_W-1:0]   DEF_A       = 5,
  parameter logic [N_W-1:0]   DEF_N       = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_data_i,
  input  logic           ser_clk_i,
  input  logic           ser_le_i,
  output logic [R_W-1:0] r_cnt_o,
  output logic           sw_o,
  output logic [A_W-1:0] a_cnt_o,
  output logic [N_W-1:0] n_cnt_o
);
  localparam int unsigned REF_LEN = R_W + 2;
  localparam int unsigned PRG_LEN = A_W + N_W + 1;
  localparam int unsigned SR_LEN  = max2(REF_LEN, PRG_LEN);
  localparam int unsigned REF_OFF = SR_LEN - REF_LEN;
  localparam int unsigned PRG_OFF = SR_LEN - PRG_LEN;

  logic data_lvl, sclk_lvl, le_lvl;
  logic sclk_rise, le_rise;
  logic shift_en, ctrl, load_ref, load_prg;
  logic [SR_LEN-1:0] sr;

  sdl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_data (
    .clk_i, .rst_ni, .async_i(ser_data_i), .level_o(data_lvl));
  sdl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
    .clk_i, .rst_ni, .async_i(ser_clk_i), .level_o(sclk_lvl));
  // load enable rests high: reset to 1 so release of reset is not a rise
  sdl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_le (
    .clk_i, .rst_ni, .async_i(ser_le_i), .level_o(le_lvl));

  sdl_edge #(.RST_VAL(1'b0)) i_edge_sclk (
    .clk_i, .rst_ni, .level_i(sclk_lvl), .rise_o(sclk_rise));
  sdl_edge #(.RST_VAL(1'b1)) i_edge_le (
    .clk_i, .rst_ni, .level_i(le_lvl), .rise_o(le_rise));

  assign shift_en = sclk_rise & ~le_lvl;

  sdl_shift #(.LEN(SR_LEN)) i_shift (
    .clk_i, .rst_ni, .shift_en_i(shift_en), .bit_i(data_lvl), .sr_o(sr));

  assign ctrl     = sr[SR_LEN-1];
  assign load_ref = le_rise &  ctrl;
  assign load_prg = le_rise & ~ctrl;

  sdl_latch #(.W(R_W+1), .DEF({DEF_SW, DEF_R})) i_ref_latch (
    .clk_i, .rst_ni, .load_i(load_ref),
    .d_i({sr[REF_OFF+R_W], sr[REF_OFF +: R_W]}),
    .q_o({sw_o, r_cnt_o}));

  sdl_latch #(.W(A_W+N_W), .DEF({DEF_N, DEF_A})) i_prg_latch (
    .clk_i, .rst_ni, .load_i(load_prg),
    .d_i(sr[PRG_OFF +: A_W+N_W]),
    .q_o({n_cnt_o, a_cnt_o}));

  p_le_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_lvl |=> $stable(sr));
  p_prg_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ref |=> $stable({n_cnt_o, a_cnt_o}));
  p_ref_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_prg |=> $stable({sw_o, r_cnt_o}));
endmodule

// File: tb/test_sdl_loader.sv
module test_sdl_loader;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd = 1'b0, sc = 1'b0, le = 1'b1;
  logic [13:0] r_o;
  logic        sw_o;
  logic [6:0]  a_o;
  logic [10:0] n_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sdl_loader i_sdl_loader (
    .clk_i(clk), .rst_ni(rst_n), .ser_data_i(sd), .ser_clk_i(sc), .ser_le_i(le),
    .r_cnt_o(r_o), .sw_o(sw_o), .a_cnt_o(a_o), .n_cnt_o(n_o));

  // behavioural model: pin history queues, 2-cycle sync plus edge compare
  bit hd[$], hc[$], hl[$];
  bit [18:0] m_sr;
  int m_r, m_sw, m_a, m_n;

  task automatic model_reset();
    hd = {0, 0, 0}; hc = {0, 0, 0}; hl = {1, 1, 1};
    m_sr = '0; m_r = 100; m_sw = 0; m_a = 5; m_n = 200;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit d, c, cp, l, lp;
      hd.push_back(sd); hc.push_back(sc); hl.push_back(le);
      d = hd[hd.size()-3]; c = hc[hc.size()-3]; cp = hc[hc.size()-4];
      l = hl[hl.size()-3]; lp = hl[hl.size()-4];
      if (l && !lp) begin
        if (m_sr[18]) begin m_r = int'(m_sr[16:3]); m_sw = int'(m_sr[17]); end
        else begin m_a = int'(m_sr[6:0]); m_n = int'(m_sr[17:7]); end
      end else if (c && !cp && !l) m_sr = {d, m_sr[18:1]};
      if (hd.size() > 8) begin
        void'(hd.pop_front()); void'(hc.pop_front()); void'(hl.pop_front());
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R8 model r_cnt", int'(r_o), m_r);
    chk("R8 model sw", int'(sw_o), m_sw);
    chk("R8 model a_cnt", int'(a_o), m_a);
    chk("R8 model n_cnt", int'(n_o), m_n);
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit [18:0] w, int len);
    le = 1'b0; wait_n(4);
    for (int i = 0; i < len; i++) begin
      sd = w[i]; wait_n(2);
      sc = 1'b1; wait_n(3);
      sc = 1'b0; wait_n(2);
    end
  endtask

  task automatic load();
    le = 1'b0; wait_n(4);
    le = 1'b1; wait_n(6);
  endtask

  function automatic bit [18:0] prg_word(int a, int n);
    return {1'b0, 11'(n), 7'(a)};
  endfunction
  function automatic bit [18:0] ref_word(int r, int s);
    return {3'b000, 1'b1, 1'(s), 14'(r)};
  endfunction

  initial begin
    wait_n(3);
    chk("R1 reset r_cnt", int'(r_o), 100);
    chk("R1 reset sw", int'(sw_o), 0);
    chk("R1 reset a_cnt", int'(a_o), 5);
    chk("R1 reset n_cnt", int'(n_o), 200);
    rst_n = 1'b1; wait_n(4);

    // R1: cleared shift register loads zeros into programmable latch
    load();
    chk("R1 cleared a_cnt", int'(a_o), 0);
    chk("R1 cleared n_cnt", int'(n_o), 0);
    chk("R1 ref untouched", int'(r_o), 100);

    // R2 R4: programmable word, LSB first
    send(prg_word(7'h55, 11'h4A3), 19);
    chk("R8 no change while shifting", int'(a_o), 0);
    le = 1'b1; wait_n(6);
    chk("R4 a_cnt", int'(a_o), 7'h55);
    chk("R4 n_cnt", int'(n_o), 11'h4A3);
    chk("R4 ref kept", int'(r_o), 100);

    // R5 R3: stray bits then 16-bit reference word
    send(19'b101, 3);
    send(ref_word(14'h1ACE, 1), 16);
    le = 1'b1; wait_n(6);
    chk("R3 r_cnt", int'(r_o), 14'h1ACE);
    chk("R3 sw", int'(sw_o), 1);
    chk("R3 prg kept a", int'(a_o), 7'h55);
    chk("R5 prg kept n", int'(n_o), 11'h4A3);

    // R6: clock edges while LE high are ignored; reload gives the same word
    for (int i = 0; i < 19; i++) begin
      sd = 1'b1; wait_n(2); sc = 1'b1; wait_n(3); sc = 1'b0; wait_n(2);
    end
    chk("R7 no reload while high", int'(r_o), 14'h1ACE);
    load();
    chk("R6 r_cnt after reload", int'(r_o), 14'h1ACE);
    chk("R6 sw after reload", int'(sw_o), 1);

    // R2: second reference word with different pattern
    send(ref_word(14'h2001, 0), 16);
    le = 1'b1; wait_n(6);
    chk("R2 r_cnt pattern", int'(r_o), 14'h2001);
    chk("R2 sw pattern", int'(sw_o), 0);

    // R7: extra shift edge coincident with LE rise is dropped
    send(prg_word(7'h0A, 11'h7FF), 19);
    sd = 1'b1; wait_n(2);
    sc = 1'b1; le = 1'b1; wait_n(6);
    sc = 1'b0; wait_n(4);
    chk("R7 coincident a_cnt", int'(a_o), 7'h0A);
    chk("R7 coincident n_cnt", int'(n_o), 11'h7FF);
    chk("R7 coincident ref kept", int'(r_o), 14'h2001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule